// File: doc/BRIEF.md
# Privileged RAM Controller with Selectable Wait State

This block is a bus slave that sits in front of an on-chip scratch RAM divided into equal regions (8 KB each by default) and a bank of sixteen control-register word slots. A master presents one request at a time: address, access size, write data and a set of attribute bits. The attributes say whether the access is privileged, whether it is a data or an instruction access, whether the core issued it, and whether address relocation is in force. The block answers every completed request with a single pulse on exactly one of three outputs: ready, a core-directed storage error, or a machine-check error for any other master.

Every region carries its own three protection flags: write-protected, data-fetch-only and privileged-only. These are enforced only while the relocation attribute is high. Control registers are open to privileged data accesses alone. A failing access never alters storage and always reads back as zero. A mode bit adds one wait cycle to every access. An abort input cancels an access before it commits.

Top module: `prc_ram_ctrl`

## Requirements
- R1: Size code 0 is a byte, 1 an aligned half-word and 2 a word. Lanes are little-endian: byte offset k within a word uses bits 8k+7:8k of both write and read data. Lanes the access does not select read as zero.
- R2: While mode bit 0 of register slot 0 is clear, a request sampled at clock edge N gets its response pulse right after edge N.
- R3: While that mode bit is set, the response comes one cycle later, after edge N+1. No response appears after edge N. A request presented during the wait cycle is ignored.
- R4: Register slot 1 holds 3 protection bits per region r: bit 3r makes the region write-protected, bit 3r+1 data-fetch-only and bit 3r+2 privileged-only. A violating access is an error. These flags are checked only while attr_reloc is high.
- R5: Register slots (address MSB set, slot number in address bits 5:2) are accessible only when both attr_super and attr_data are high. Any other access to them is an error.
- R6: These accesses are errors: slots 12 to 15, array offsets at or beyond NUM_REGIONS*REGION_BYTES, size code 3, and a half-word or word that is not naturally aligned.
- R7: An erroring write leaves the array and the registers unchanged. An erroring read returns all zeros.
- R8: An error is reported on rsp_err_dsi when attr_core is high and on rsp_err_mce otherwise.
- R9: req_abort together with a request means the request is not taken. req_abort during the wait cycle cancels the pending access. In both cases nothing is written and no response is given.
- R10: Reset clears the mode bit and all protection bits. Scratch slots 2 to 11 keep their contents through reset. All three response outputs read zero during reset.
- R11: At most one of the three response outputs is high in any cycle. A response appears only for a completed access. rsp_rdata is zero for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code |
| req_addr | input | ADDR_W | Byte address; MSB selects register space |
| req_wdata | input | 32 | Lane-aligned write data |
| attr_super | input | 1 | Privileged access |
| attr_data | input | 1 | Data access (0 = instruction) |
| attr_core | input | 1 | Issued by the core |
| attr_reloc | input | 1 | Relocation active; enables region checks |
| req_abort | input | 1 | Cancel the request or the pending access |
| rsp_ready | output | 1 | Access completed without error |
| rsp_err_dsi | output | 1 | Error for a core access |
| rsp_err_mce | output | 1 | Error for a non-core access |
| rsp_rdata | output | 32 | Read data, zero on error or write |

## Verification
The bench builds the block with ADDR_W=9, REGION_BYTES=64 and NUM_REGIONS=3. This gives three short regions plus an unimplemented quarter of the array window, all reachable with small addresses, so region-index decoding and the out-of-range check are both exercised. At these sizes one register write can set protection flags on two regions at once, and a few accesses then cover every flag, with and without relocation. The mode bit is switched both ways to test the wait-cycle path, including requests and aborts that land during the wait cycle.

// File: rtl/prc_pkg.sv
package prc_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_BAD  = 2'd3
   } acc_size_e;

   localparam int unsigned REG_SLOTS = 16;
   localparam int unsigned REG_LIVE  = 12;
   localparam int unsigned SLOT_MODE = 0;
   localparam int unsigned SLOT_PROT = 1;
   localparam int unsigned SLOT_SCR0 = 2;
   localparam int unsigned PROT_W    = 3;
   localparam int unsigned PB_WPROT  = 0;
   localparam int unsigned PB_DONLY  = 1;
   localparam int unsigned PB_SONLY  = 2;
endpackage

// File: rtl/prc_decode.sv
module prc_decode
   import prc_pkg::*;
#(
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned REGION_BYTES = 8192,
   parameter int unsigned NUM_REGIONS  = 2,
   localparam int unsigned PROT_BITS   = PROT_W * NUM_REGIONS,
   localparam int unsigned IMPL_BYTES  = REGION_BYTES * NUM_REGIONS,
   localparam int unsigned WORDS       = IMPL_BYTES / 4,
   localparam int unsigned WIDX_W      = (WORDS > 1) ? $clog2(WORDS) : 1
)(
   input  logic [ADDR_W-1:0]    addr,
   input  logic [1:0]           size,
   input  logic                 write,
   input  logic                 sup,
   input  logic                 dat,
   input  logic                 reloc,
   input  logic [PROT_BITS-1:0] prot,
   output logic                 is_reg,
   output logic [3:0]           slot,
   output logic [WIDX_W-1:0]    widx,
   output logic [3:0]           be,
   output logic                 err
);
   localparam int unsigned OFF_W = ADDR_W - 1;
   localparam int unsigned RB_SH = $clog2(REGION_BYTES);
   localparam logic [ADDR_W-1:0] IMPL_LIM = ADDR_W'(IMPL_BYTES);

   logic [OFF_W-1:0]       off;
   logic [OFF_W-1:0]       region;
   logic                   size_bad;
   logic                   misalign;
   logic                   arr_miss;
   logic                   reg_bad;
   logic [NUM_REGIONS-1:0] viol;

   assign is_reg = addr[ADDR_W-1];
   assign off    = addr[OFF_W-1:0];
   assign slot   = addr[5:2];
   assign widx   = off[WIDX_W+1:2];
   assign region = off >> RB_SH;

   assign size_bad = (size == SZ_BAD);

   always_comb begin
      misalign = 1'b0;
      be       = 4'b0000;
      case (size)
         SZ_BYTE: be = 4'b0001 << off[1:0];
         SZ_HALF: begin
            misalign = off[0];
            be       = {off[1], off[1], !off[1], !off[1]};
         end
         SZ_WORD: begin
            misalign = |off[1:0];
            be       = 4'b1111;
         end
         default: be = 4'b0000;
      endcase
   end

   assign arr_miss = !is_reg && ({1'b0, off} >= IMPL_LIM);
   assign reg_bad  = is_reg && ((slot >= 4'(REG_LIVE)) || !(sup && dat));

   generate
      for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
         logic hit;
         assign hit = !is_reg && reloc && (region == OFF_W'(r));
         assign viol[r] = hit &&
            ((prot[PROT_W*r + PB_WPROT] && write) ||
             (prot[PROT_W*r + PB_DONLY] && !dat)  ||
             (prot[PROT_W*r + PB_SONLY] && !sup));
      end
   endgenerate

   assign err = size_bad | misalign | arr_miss | reg_bad | (|viol);
endmodule

// File: rtl/prc_array.sv
module prc_array #(
   parameter int unsigned WORDS  = 4096,
   parameter int unsigned WIDX_W = 12
)(
   input  logic              clk,
   input  logic              we,
   input  logic [WIDX_W-1:0] widx,
   input  logic [3:0]        be,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata
);
   logic [31:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (we) begin
         for (int l = 0; l < 4; l++) begin
            if (be[l]) mem[widx][8*l +: 8] <= wdata[8*l +: 8];
         end
      end
   end

   assign rdata = mem[widx];
endmodule

// File: rtl/prc_regs.sv
module prc_regs
   import prc_pkg::*;
#(
   parameter int unsigned NUM_REGIONS = 2,
   localparam int unsigned PROT_BITS  = PROT_W * NUM_REGIONS
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [3:0]           slot,
   input  logic [3:0]           be,
   input  logic [31:0]          wdata,
   output logic [31:0]          rdata,
   output logic                 two_cyc,
   output logic [PROT_BITS-1:0] prot
);
   localparam int unsigned N_SCR = REG_LIVE - SLOT_SCR0;

   logic [31:0]          mask;
   logic                 mode_q;
   logic [PROT_BITS-1:0] prot_q;
   logic [31:0]          scr_q [N_SCR];

   assign mask = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         prot_q <= '0;
      end else if (we) begin
         if (slot == 4'(SLOT_MODE) && be[0]) mode_q <= wdata[0];
         if (slot == 4'(SLOT_PROT))
            prot_q <= (prot_q & ~mask[PROT_BITS-1:0]) |
                      (wdata[PROT_BITS-1:0] & mask[PROT_BITS-1:0]);
      end
   end

   always_ff @(posedge clk) begin
      if (we) begin
         for (int s = 0; s < int'(N_SCR); s++) begin
            if (slot == 4'(s + SLOT_SCR0))
               scr_q[s] <= (scr_q[s] & ~mask) | (wdata & mask);
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (slot == 4'(SLOT_MODE))
         rdata[0] = mode_q;
      else if (slot == 4'(SLOT_PROT))
         rdata[PROT_BITS-1:0] = prot_q;
      else if (slot < 4'(REG_LIVE))
         rdata = scr_q[slot - 4'(SLOT_SCR0)];
   end

   assign two_cyc = mode_q;
   assign prot    = prot_q;
endmodule

// File: rtl/prc_ram_ctrl.sv
module prc_ram_ctrl
   import prc_pkg::*;
#(
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned REGION_BYTES = 8192,
   parameter int unsigned NUM_REGIONS  = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   input  logic              attr_super,
   input  logic              attr_data,
   input  logic              attr_core,
   input  logic              attr_reloc,
   input  logic              req_abort,
   output logic              rsp_ready,
   output logic              rsp_err_dsi,
   output logic              rsp_err_mce,
   output logic [31:0]       rsp_rdata
);
   localparam int unsigned PROT_BITS  = PROT_W * NUM_REGIONS;
   localparam int unsigned IMPL_BYTES = REGION_BYTES * NUM_REGIONS;
   localparam int unsigned WORDS      = IMPL_BYTES / 4;
   localparam int unsigned WIDX_W     = (WORDS > 1) ? $clog2(WORDS) : 1;

   generate
      if (ADDR_W < 8) begin : g_bad_addr
         $error("ADDR_W must leave room for the register slot field");
      end
      if (REGION_BYTES < 4 || (REGION_BYTES & (REGION_BYTES - 1)) != 0) begin : g_bad_rb
         $error("REGION_BYTES must be a power of two of at least 4");
      end
      if (NUM_REGIONS < 1 || PROT_BITS > 32) begin : g_bad_nr
         $error("NUM_REGIONS must fit three bits each in one word");
      end
      if (IMPL_BYTES > (1 << (ADDR_W - 1))) begin : g_bad_fit
         $error("array does not fit the array half of the address space");
      end
   endgenerate

   logic                 two_cyc;
   logic [PROT_BITS-1:0] prot;

   logic              pend_q;
   logic              p_write, p_super, p_data, p_core, p_reloc;
   logic [1:0]        p_size;
   logic [ADDR_W-1:0] p_addr;
   logic [31:0]       p_wdata;

   logic              accept, go;
   logic              c_write, c_super, c_data, c_core, c_reloc;
   logic [1:0]        c_size;
   logic [ADDR_W-1:0] c_addr;
   logic [31:0]       c_wdata;

   logic              d_is_reg, d_err;
   logic [3:0]        d_slot, d_be;
   logic [WIDX_W-1:0] d_widx;
   logic [31:0]       lane_mask, arr_rdata, reg_rdata, rd_word;

   assign accept = req_valid && !req_abort && !pend_q;
   assign go     = pend_q ? !req_abort : (accept && !two_cyc);

   assign c_write = pend_q ? p_write : req_write;
   assign c_super = pend_q ? p_super : attr_super;
   assign c_data  = pend_q ? p_data  : attr_data;
   assign c_core  = pend_q ? p_core  : attr_core;
   assign c_reloc = pend_q ? p_reloc : attr_reloc;
   assign c_size  = pend_q ? p_size  : req_size;
   assign c_addr  = pend_q ? p_addr  : req_addr;
   assign c_wdata = pend_q ? p_wdata : req_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else if (pend_q) pend_q <= 1'b0;
      else pend_q <= accept && two_cyc;
   end

   always_ff @(posedge clk) begin
      if (!pend_q && accept && two_cyc) begin
         p_write <= req_write;
         p_super <= attr_super;
         p_data  <= attr_data;
         p_core  <= attr_core;
         p_reloc <= attr_reloc;
         p_size  <= req_size;
         p_addr  <= req_addr;
         p_wdata <= req_wdata;
      end
   end

   prc_decode #(
      .ADDR_W(ADDR_W), .REGION_BYTES(REGION_BYTES), .NUM_REGIONS(NUM_REGIONS)
   ) u_dec (
      .addr(c_addr), .size(c_size), .write(c_write), .sup(c_super),
      .dat(c_data), .reloc(c_reloc), .prot(prot),
      .is_reg(d_is_reg), .slot(d_slot), .widx(d_widx), .be(d_be), .err(d_err)
   );

   prc_array #(.WORDS(WORDS), .WIDX_W(WIDX_W)) u_arr (
      .clk(clk), .we(go && c_write && !d_err && !d_is_reg),
      .widx(d_widx), .be(d_be), .wdata(c_wdata), .rdata(arr_rdata)
   );

   prc_regs #(.NUM_REGIONS(NUM_REGIONS)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(go && c_write && !d_err && d_is_reg),
      .slot(d_slot), .be(d_be), .wdata(c_wdata), .rdata(reg_rdata),
      .two_cyc(two_cyc), .prot(prot)
   );

   assign lane_mask = {{8{d_be[3]}}, {8{d_be[2]}}, {8{d_be[1]}}, {8{d_be[0]}}};
   assign rd_word   = (d_is_reg ? reg_rdata : arr_rdata) & lane_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_ready   <= 1'b0;
         rsp_err_dsi <= 1'b0;
         rsp_err_mce <= 1'b0;
         rsp_rdata   <= '0;
      end else begin
         rsp_ready   <= go && !d_err;
         rsp_err_dsi <= go && d_err && c_core;
         rsp_err_mce <= go && d_err && !c_core;
         rsp_rdata   <= (go && !d_err && !c_write) ? rd_word : '0;
      end
   end
endmodule

// File: rtl/prc_ram_ctrl_chk.sv
module prc_ram_ctrl_chk #(
   parameter int unsigned ADDR_W = 16
)(
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_abort,
   input logic [ADDR_W-1:0] req_addr,
   input logic              attr_super,
   input logic              attr_data,
   input logic              attr_core,
   input logic              two_cyc,
   input logic              pend_q,
   input logic              rsp_ready,
   input logic              rsp_err_dsi,
   input logic              rsp_err_mce,
   input logic [31:0]       rsp_rdata
);
   logic any_rsp, take_now;
   assign any_rsp  = rsp_ready || rsp_err_dsi || rsp_err_mce;
   assign take_now = req_valid && !req_abort && !pend_q && !two_cyc;

   // R11
   rsp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_ready, rsp_err_dsi, rsp_err_mce}));

   // R7
   err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_err_dsi || rsp_err_mce) |-> (rsp_rdata == 32'd0));

   // R2
   single_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_now |=> any_rsp);

   // R3
   wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> !any_rsp);

   // R3
   wait_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !req_abort) |=> any_rsp);

   // R9
   abort_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && req_abort) |=> !any_rsp);

   // R11
   rsp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_rsp |-> $past((req_valid && !req_abort) || pend_q));

   // R5
   reg_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_now && req_addr[ADDR_W-1] && !(attr_super && attr_data))
      |=> (rsp_err_dsi || rsp_err_mce));

   // R8
   core_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_now && attr_core) |=> !rsp_err_mce);

   // R8
   other_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_now && !attr_core) |=> !rsp_err_dsi);
endmodule

bind prc_ram_ctrl prc_ram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/prc_ram_ctrl_test.sv
`timescale 1ns/1ps
module prc_ram_ctrl_test;
   localparam int unsigned AW = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0, req_abort = 1'b0;
   logic [1:0]    req_size = 2'd0;
   logic [AW-1:0] req_addr = '0;
   logic [31:0]   req_wdata = '0;
   logic          attr_super = 1'b0, attr_data = 1'b0, attr_core = 1'b0, attr_reloc = 1'b0;
   logic          rsp_ready, rsp_err_dsi, rsp_err_mce;
   logic [31:0]   rsp_rdata;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;
   bit  two_cyc_tb = 1'b0;

   always #10 clk = ~clk;

   prc_ram_ctrl #(.ADDR_W(AW), .REGION_BYTES(64), .NUM_REGIONS(3)) uut (.*);

   // attribute nibble {super, data, core, reloc}
   localparam logic [3:0] A_SDC  = 4'b1110, A_SDM  = 4'b1100, A_UDM  = 4'b0100;
   localparam logic [3:0] A_SIC  = 4'b1010, A_SDCR = 4'b1111, A_UDCR = 4'b0111;
   localparam logic [3:0] A_UDC  = 4'b0110, A_UDMR = 4'b0101, A_SICR = 4'b1011;

   // expected kind: 0 ready, 1 core error, 2 machine check, 3 no response
   typedef struct packed {
      logic [3:0]  rq;
      logic        w;
      logic [1:0]  sz;
      logic [8:0]  a;
      logic [31:0] wd;
      logic [3:0]  at;
      logic [1:0]  ek;
      logic [31:0] er;
   } vec_t;

   localparam int NV = 33;
   localparam vec_t VEC [NV] = '{
      '{4'd1,  1'b1, 2'd2, 9'h000, 32'h11223344, A_SDC,  2'd0, 32'h0},        // R1
      '{4'd1,  1'b0, 2'd2, 9'h000, 32'h0,        A_SDC,  2'd0, 32'h11223344}, // R1
      '{4'd1,  1'b1, 2'd2, 9'h004, 32'h0,        A_SDC,  2'd0, 32'h0},
      '{4'd1,  1'b1, 2'd0, 9'h005, 32'h0000AA00, A_SDC,  2'd0, 32'h0},
      '{4'd1,  1'b0, 2'd2, 9'h004, 32'h0,        A_SDC,  2'd0, 32'h0000AA00},
      '{4'd1,  1'b1, 2'd1, 9'h006, 32'hBEEF0000, A_SDC,  2'd0, 32'h0},
      '{4'd1,  1'b0, 2'd0, 9'h007, 32'h0,        A_SDC,  2'd0, 32'hBE000000},
      '{4'd1,  1'b0, 2'd1, 9'h002, 32'h0,        A_SDC,  2'd0, 32'h11220000},
      '{4'd6,  1'b0, 2'd1, 9'h001, 32'h0,        A_SDC,  2'd1, 32'h0},        // R6 misaligned
      '{4'd6,  1'b0, 2'd2, 9'h0C0, 32'h0,        A_SDM,  2'd2, 32'h0},        // R6 unimplemented
      '{4'd6,  1'b0, 2'd3, 9'h000, 32'h0,        A_SDC,  2'd1, 32'h0},        // R6 size code 3
      '{4'd6,  1'b0, 2'd2, 9'h130, 32'h0,        A_SDC,  2'd1, 32'h0},        // R6 reserved slot
      '{4'd5,  1'b1, 2'd2, 9'h108, 32'hCAFEF00D, A_SDC,  2'd0, 32'h0},
      '{4'd5,  1'b0, 2'd2, 9'h108, 32'h0,        A_SDC,  2'd0, 32'hCAFEF00D},
      '{4'd5,  1'b0, 2'd2, 9'h108, 32'h0,        A_UDM,  2'd2, 32'h0},        // R5 user
      '{4'd5,  1'b1, 2'd2, 9'h108, 32'h0,        A_SIC,  2'd1, 32'h0},        // R5 instruction
      '{4'd7,  1'b0, 2'd2, 9'h108, 32'h0,        A_SDC,  2'd0, 32'hCAFEF00D}, // R7
      '{4'd7,  1'b1, 2'd2, 9'h002, 32'hFFFFFFFF, A_SDC,  2'd1, 32'h0},
      '{4'd7,  1'b0, 2'd2, 9'h000, 32'h0,        A_SDC,  2'd0, 32'h11223344},
      '{4'd4,  1'b1, 2'd2, 9'h040, 32'h55555555, A_SDC,  2'd0, 32'h0},
      '{4'd4,  1'b1, 2'd2, 9'h104, 32'h00000108, A_SDC,  2'd0, 32'h0},        // R4 region1 wprot, region2 priv
      '{4'd4,  1'b1, 2'd2, 9'h040, 32'h0,        A_SDCR, 2'd1, 32'h0},
      '{4'd4,  1'b0, 2'd2, 9'h040, 32'h0,        A_SDCR, 2'd0, 32'h55555555},
      '{4'd4,  1'b1, 2'd2, 9'h040, 32'h0,        A_SDC,  2'd0, 32'h0},        // R4 no reloc
      '{4'd4,  1'b0, 2'd2, 9'h040, 32'h0,        A_SDC,  2'd0, 32'h0},
      '{4'd4,  1'b1, 2'd2, 9'h080, 32'h77,       A_UDCR, 2'd1, 32'h0},
      '{4'd4,  1'b1, 2'd2, 9'h080, 32'h77,       A_UDC,  2'd0, 32'h0},
      '{4'd8,  1'b0, 2'd2, 9'h080, 32'h0,        A_UDMR, 2'd2, 32'h0},        // R8
      '{4'd4,  1'b0, 2'd2, 9'h080, 32'h0,        A_SDCR, 2'd0, 32'h77},
      '{4'd4,  1'b0, 2'd2, 9'h104, 32'h0,        A_SDC,  2'd0, 32'h108},
      '{4'd4,  1'b1, 2'd2, 9'h104, 32'h00000010, A_SDC,  2'd0, 32'h0},        // R4 region1 data-only
      '{4'd4,  1'b0, 2'd2, 9'h040, 32'h0,        A_SICR, 2'd1, 32'h0},
      '{4'd4,  1'b0, 2'd2, 9'h040, 32'h0,        A_SDCR, 2'd0, 32'h0}
   };

   task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   function automatic logic [1:0] kind_of();
      if (rsp_ready)   return 2'd0;
      if (rsp_err_dsi) return 2'd1;
      if (rsp_err_mce) return 2'd2;
      return 2'd3;
   endfunction

   task automatic acc(input logic w, input logic [1:0] sz, input logic [AW-1:0] a,
                      input logic [31:0] wd, input logic [3:0] at,
                      input logic ab_req, input logic ab_wait, input logic inject,
                      output logic [1:0] kind, output logic [31:0] rd, output logic early);
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a; req_wdata = wd;
      {attr_super, attr_data, attr_core, attr_reloc} = at;
      req_abort = ab_req;
      @(negedge clk);
      early = 1'b0;
      if (two_cyc_tb) begin
         early = rsp_ready | rsp_err_dsi | rsp_err_mce;
         req_valid = inject; req_write = 1'b1; req_size = 2'd2;
         req_addr = '0; req_wdata = 32'hDEAD0000; req_abort = ab_wait;
         @(negedge clk);
      end
      kind = kind_of();
      rd   = rsp_rdata;
      req_valid = 1'b0; req_abort = 1'b0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [1:0]  k;
      logic [31:0] d;
      logic        e;

      repeat (3) @(negedge clk);
      // R10 outputs quiet in reset
      chk("R10", "reset outputs", {29'd0, rsp_ready, rsp_err_dsi, rsp_err_mce}, 32'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         acc(VEC[i].w, VEC[i].sz, VEC[i].a, VEC[i].wd, VEC[i].at, 1'b0, 1'b0, 1'b0, k, d, e);
         chk($sformatf("R%0d", VEC[i].rq), $sformatf("vec %0d kind", i), 32'(k), 32'(VEC[i].ek));
         chk($sformatf("R%0d", VEC[i].rq), $sformatf("vec %0d data", i), d, VEC[i].er);
      end

      // R3: switch to the wait-cycle mode
      acc(1'b1, 2'd2, 9'h100, 32'h1, A_SDC, 1'b0, 1'b0, 1'b0, k, d, e);
      chk("R3", "mode set", 32'(k), 32'd0);
      two_cyc_tb = 1'b1;
      acc(1'b0, 2'd2, 9'h000, 32'h0, A_SDC, 1'b0, 1'b0, 1'b1, k, d, e);
      chk("R3", "no early response", 32'(e), 32'd0);
      chk("R3", "late kind", 32'(k), 32'd0);
      chk("R3", "late data", d, 32'h11223344);
      acc(1'b0, 2'd2, 9'h000, 32'h0, A_SDC, 1'b0, 1'b0, 1'b0, k, d, e);
      chk("R3", "wait-cycle request ignored", d, 32'h11223344);

      // R9: abort during the wait cycle
      acc(1'b1, 2'd2, 9'h000, 32'h99, A_SDC, 1'b0, 1'b1, 1'b0, k, d, e);
      chk("R9", "aborted pending kind", 32'(k), 32'd3);
      chk("R9", "aborted pending early", 32'(e), 32'd0);
      acc(1'b0, 2'd2, 9'h000, 32'h0, A_SDC, 1'b0, 1'b0, 1'b0, k, d, e);
      chk("R9", "aborted write left data", d, 32'h11223344);

      // R11: write responses carry zero data
      acc(1'b1, 2'd2, 9'h004, 32'h1, A_SDC, 1'b0, 1'b0, 1'b0, k, d, e);
      chk("R11", "write data zero", d, 32'd0);

      // R2: back to single-cycle mode (this access still takes two)
      acc(1'b1, 2'd2, 9'h100, 32'h0, A_SDC, 1'b0, 1'b0, 1'b0, k, d, e);
      chk("R2", "mode clear", 32'(k), 32'd0);
      two_cyc_tb = 1'b0;

      // R9: abort together with the request
      acc(1'b1, 2'd2, 9'h000, 32'h77, A_SDC, 1'b1, 1'b0, 1'b0, k, d, e);
      chk("R9", "aborted request kind", 32'(k), 32'd3);
      acc(1'b0, 2'd2, 9'h000, 32'h0, A_SDC, 1'b0, 1'b0, 1'b0, k, d, e);
      chk("R9", "aborted request left data", d, 32'h11223344);

      // R10: reset keeps scratch, clears mode and protection
      acc(1'b1, 2'd2, 9'h104, 32'h1FF, A_SDC, 1'b0, 1'b0, 1'b0, k, d, e);
      acc(1'b1, 2'd2, 9'h10C, 32'h12345678, A_SDC, 1'b0, 1'b0, 1'b0, k, d, e);
      acc(1'b1, 2'd2, 9'h100, 32'h1, A_SDC, 1'b0, 1'b0, 1'b0, k, d, e);
      @(negedge clk);
      rst_n = 1'b0;
      two_cyc_tb = 1'b0;
      @(negedge clk);
      chk("R10", "outputs in reset", {29'd0, rsp_ready, rsp_err_dsi, rsp_err_mce}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      acc(1'b0, 2'd2, 9'h100, 32'h0, A_SDC, 1'b0, 1'b0, 1'b0, k, d, e);
      chk("R10", "mode after reset", d, 32'd0);
      acc(1'b0, 2'd2, 9'h104, 32'h0, A_SDC, 1'b0, 1'b0, 1'b0, k, d, e);
      chk("R10", "protection after reset", d, 32'd0);
      acc(1'b0, 2'd2, 9'h10C, 32'h0, A_SDC, 1'b0, 1'b0, 1'b0, k, d, e);
      chk("R10", "scratch kept", d, 32'h12345678);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule